// File: doc/BRIEF.md
# Ordered Oscillator Trim-Code Sequencer

This block turns a numeric delay setting into the control word for a tunable ring oscillator of 13 delay stages. Each stage has two trim inputs: a primary one and a secondary one. The secondary input changes nothing unless the primary input of the same stage is already asserted. The sequencer therefore fills the word as a two-tier thermometer code. All primary bits are set first, in the low half of the word, and only then are secondary bits set, in the high half. Every step of the setting adds or removes one unit of delay, in roughly equal increments.

Software or a tuning loop can write an absolute setting. It can also nudge the setting one unit at a time with up and down commands. The current value is read back alongside the registered trim word. When a step is refused because the range end has been reached, a one-cycle flag reports it. The word is always ordered, so it can drive the oscillator directly.

Top module: `trim_code_seq`

## Requirements
- R1: A synchronous active-high `rst` sets `cur_val` to 0, `trim_word` to all zeros, and both saturation flags to 0.
- R2: For a held value v in the range 0 to 26, `trim_word` has exactly bits 0 through v-1 set. Bit i (i < 13) is the primary trim of stage i. Bit i+13 is the secondary trim of stage i. Values 0 to 13 therefore fill primaries only, and value 13+m also sets secondaries 13 through 13+m-1.
- R3: The number of set bits in `trim_word` always equals `cur_val`.
- R4: No bit i+13 is ever set while bit i is clear.
- R5: `load_en` with `load_val` makes the held value equal to `load_val`. A `load_val` above 26 holds 26 instead.
- R6: Without a load, `up_step` alone raises the value by one by setting the next bit. `dn_step` alone lowers it by one by clearing the highest set bit. The word changes in at most one bit per clock on a step.
- R7: An `up_step` at value 26 leaves value and word unchanged and pulses `sat_hi` high for exactly one cycle. A `dn_step` at value 0 leaves them unchanged and pulses `sat_lo` for one cycle. Otherwise both flags stay low.
- R8: When `load_en` is asserted together with either step command, the load alone takes effect and neither flag rises.
- R9: `up_step` and `dn_step` asserted together without a load leave the value and word unchanged and raise no flag.
- R10: A command sampled at a rising clock edge updates `cur_val`, `trim_word` and the flags at that same edge. The outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load an absolute setting this cycle |
| load_val | input | 6 | Absolute setting to load (clamped to 26) |
| up_step | input | 1 | Add one unit of delay |
| dn_step | input | 1 | Remove one unit of delay |
| trim_word | output | 26 | Registered oscillator trim word; primaries in bits 0-12, secondaries in bits 13-25 |
| cur_val | output | 5 | Currently held setting, 0 to 26 |
| sat_hi | output | 1 | One-cycle pulse: up step refused at the top of the range |
| sat_lo | output | 1 | One-cycle pulse: down step refused at the bottom of the range |

## Verification
Two functions can fall in the same clock: an absolute load and a step command. Up and down steps can also coincide with each other. The bench provokes both cases by driving the conflicting controls in the same cycle, including a load issued at the range ends while a step points out of range. It then judges the outcome by the loaded value, the exact word, and the absence of any saturation pulse. After every operation the bench also recounts the word's set bits and checks the primary/secondary ordering against the value it expects.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    // Resolved command for one clock, in priority order.
    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_LOAD   = 3'd1,
        CMD_UP     = 3'd2,
        CMD_DOWN   = 3'd3,
        CMD_CANCEL = 3'd4
    } cmd_e;

    // Saturation report for one clock.
    typedef struct packed {
        logic hi;
        logic lo;
    } sat_t;

    // Load wins over any step; opposing steps cancel.
    function automatic cmd_e resolve_cmd(input logic ld, input logic up, input logic dn);
        cmd_e c;
        if (ld)
            c = CMD_LOAD;
        else if (up && dn)
            c = CMD_CANCEL;
        else if (up)
            c = CMD_UP;
        else if (dn)
            c = CMD_DOWN;
        else
            c = CMD_IDLE;
        return c;
    endfunction

endpackage

// File: rtl/tcs_cmd_decode.sv
module tcs_cmd_decode
    import tcs_pkg::*;
(
    input  logic load_en,
    input  logic up_step,
    input  logic dn_step,
    output cmd_e cmd
);

    always_comb begin
        cmd = resolve_cmd(load_en, up_step, dn_step);
    end

endmodule

// File: rtl/tcs_next_val.sv
module tcs_next_val
    import tcs_pkg::*;
#(
    parameter int VAL_W  = 5,
    parameter int LOAD_W = 6,
    parameter int MAX    = 26
) (
    input  cmd_e              cmd,
    input  logic [VAL_W-1:0]  cur,
    input  logic [LOAD_W-1:0] load_val,
    output logic [VAL_W-1:0]  nxt,
    output sat_t              sat
);

    localparam logic [VAL_W-1:0] TOP = VAL_W'(MAX);
    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    logic at_top;
    logic at_bot;

    assign at_top = (cur == TOP);
    assign at_bot = (cur == '0);

    always_comb begin
        nxt    = cur;
        sat.hi = 1'b0;
        sat.lo = 1'b0;
        unique case (cmd)
            CMD_LOAD: begin
                if (32'(load_val) > MAX)
                    nxt = TOP;
                else
                    nxt = VAL_W'(load_val);
            end
            CMD_UP: begin
                if (at_top)
                    sat.hi = 1'b1;
                else
                    nxt = cur + ONE;
            end
            CMD_DOWN: begin
                if (at_bot)
                    sat.lo = 1'b1;
                else
                    nxt = cur - ONE;
            end
            default: begin
                nxt = cur;
            end
        endcase
    end

endmodule

// File: rtl/tcs_encoder.sv
module tcs_encoder #(
    parameter int STAGES = 13,
    parameter int VAL_W  = 5
) (
    input  logic [VAL_W-1:0]    val,
    output logic [2*STAGES-1:0] word
);

    // Per stage: primary in the low half, secondary in the high half.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        assign word[s]          = (val > VAL_W'(s));
        assign word[STAGES + s] = (val > VAL_W'(STAGES + s));
    end

endmodule

// File: rtl/trim_code_seq.sv
module trim_code_seq
    import tcs_pkg::*;
#(
    parameter int STAGES = 13,
    parameter int LOAD_W = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             load_en,
    input  logic [LOAD_W-1:0]                load_val,
    input  logic                             up_step,
    input  logic                             dn_step,
    output logic [2*STAGES-1:0]              trim_word,
    output logic [$clog2(2*STAGES+1)-1:0]    cur_val,
    output logic                             sat_hi,
    output logic                             sat_lo
);

    localparam int MAX   = 2 * STAGES;
    localparam int VAL_W = $clog2(MAX + 1);
    localparam int WRD_W = 2 * STAGES;

    cmd_e             cmd;
    logic [VAL_W-1:0] nxt_val;
    sat_t             nxt_sat;
    logic [WRD_W-1:0] nxt_word;

    tcs_cmd_decode u_dec (
        .load_en (load_en),
        .up_step (up_step),
        .dn_step (dn_step),
        .cmd     (cmd)
    );

    tcs_next_val #(
        .VAL_W  (VAL_W),
        .LOAD_W (LOAD_W),
        .MAX    (MAX)
    ) u_nxt (
        .cmd      (cmd),
        .cur      (cur_val),
        .load_val (load_val),
        .nxt      (nxt_val),
        .sat      (nxt_sat)
    );

    tcs_encoder #(
        .STAGES (STAGES),
        .VAL_W  (VAL_W)
    ) u_enc (
        .val  (nxt_val),
        .word (nxt_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_val   <= '0;
            trim_word <= '0;
            sat_hi    <= 1'b0;
            sat_lo    <= 1'b0;
        end else begin
            cur_val   <= nxt_val;
            trim_word <= nxt_word;
            sat_hi    <= nxt_sat.hi;
            sat_lo    <= nxt_sat.lo;
        end
    end

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
    parameter int STAGES = 13,
    parameter int LOAD_W = 6
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          load_en,
    input logic                          up_step,
    input logic                          dn_step,
    input logic [2*STAGES-1:0]           trim_word,
    input logic [$clog2(2*STAGES+1)-1:0] cur_val,
    input logic                          sat_hi,
    input logic                          sat_lo
);

    localparam int MAX   = 2 * STAGES;
    localparam int VAL_W = $clog2(MAX + 1);
    localparam logic [VAL_W-1:0] TOP = VAL_W'(MAX);

    assert_popcount_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(trim_word) == int'(cur_val));

    assert_order_R4: assert property (@(posedge clk) disable iff (rst)
        (trim_word[2*STAGES-1:STAGES] & ~trim_word[STAGES-1:0]) == '0);

    assert_range_R5: assert property (@(posedge clk) disable iff (rst)
        cur_val <= TOP);

    assert_onebit_R6: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $countones(trim_word ^ $past(trim_word)) <= 1);

    assert_sat_hi_R7: assert property (@(posedge clk) disable iff (rst)
        (up_step && !dn_step && !load_en && cur_val == TOP) |=> (sat_hi && $stable(trim_word)));

    assert_sat_lo_R7: assert property (@(posedge clk) disable iff (rst)
        (dn_step && !up_step && !load_en && cur_val == '0) |=> (sat_lo && $stable(trim_word)));

    assert_flag_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(sat_hi && sat_lo));

    assert_prio_R8: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (!sat_hi && !sat_lo));

    assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
        (!load_en && up_step && dn_step) |=> ($stable(cur_val) && !sat_hi && !sat_lo));

endmodule

bind trim_code_seq tcs_checker #(
    .STAGES (STAGES),
    .LOAD_W (LOAD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .up_step   (up_step),
    .dn_step   (dn_step),
    .trim_word (trim_word),
    .cur_val   (cur_val),
    .sat_hi    (sat_hi),
    .sat_lo    (sat_lo)
);

// File: tb/trim_code_seq_bench.sv
module trim_code_seq_bench;

    localparam int STAGES = 13;
    localparam int LOAD_W = 6;
    localparam int MAX    = 2 * STAGES;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_en;
    logic [5:0]  load_val;
    logic        up_step;
    logic        dn_step;
    logic [25:0] trim_word;
    logic [4:0]  cur_val;
    logic        sat_hi;
    logic        sat_lo;

    int errors = 0;
    int checks = 0;
    int mv     = 0;

    always #10 clk = ~clk;

    trim_code_seq #(.STAGES(STAGES), .LOAD_W(LOAD_W)) u_trim_code_seq (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_val  (load_val),
        .up_step   (up_step),
        .dn_step   (dn_step),
        .trim_word (trim_word),
        .cur_val   (cur_val),
        .sat_hi    (sat_hi),
        .sat_lo    (sat_lo)
    );

    // Value v sets exactly bits 0..v-1 (R2).
    function automatic logic [25:0] word_of(input int v);
        return 26'((64'd1 << v) - 64'd1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Full state check against the bench model.
    task automatic chk_state(input string req, input bit ehi, input bit elo);
        int pc;
        logic [12:0] orphan;
        pc = $countones(trim_word);
        orphan = trim_word[25:13] & ~trim_word[12:0];
        chk(int'(cur_val) == mv, req, "cur_val", int'(cur_val), mv);
        chk(trim_word == word_of(mv), req, "trim_word", int'(trim_word), int'(word_of(mv)));
        chk(pc == int'(cur_val), "R3", "popcount", pc, int'(cur_val));
        chk(orphan == '0, "R4", "orphan secondary", int'(orphan), 0);
        chk(sat_hi == ehi, req, "sat_hi", int'(sat_hi), int'(ehi));
        chk(sat_lo == elo, req, "sat_lo", int'(sat_lo), int'(elo));
    endtask

    // Drive on a falling edge, sample on the next falling edge.
    task automatic drive(input bit ld, input int lv, input bit up, input bit dn);
        @(negedge clk);
        load_en  = ld;
        load_val = 6'(lv);
        up_step  = up;
        dn_step  = dn;
        @(negedge clk);
        load_en  = 1'b0;
        up_step  = 1'b0;
        dn_step  = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        load_en = 1'b0; load_val = '0; up_step = 1'b0; dn_step = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mv = 0;
        chk_state("R1", 1'b0, 1'b0);
    endtask

    task automatic t_loads();
        int vals [7] = '{5, 13, 20, 0, 26, 40, 63};
        foreach (vals[k]) begin
            drive(1'b1, vals[k], 1'b0, 1'b0);
            mv = (vals[k] > MAX) ? MAX : vals[k];
            chk_state("R5", 1'b0, 1'b0);
        end
        drive(1'b1, 13, 1'b0, 1'b0);
        mv = 13;
        chk_state("R2", 1'b0, 1'b0);
    endtask

    task automatic t_up_sweep();
        drive(1'b1, 0, 1'b0, 1'b0);
        mv = 0;
        for (int k = 0; k < MAX; k++) begin
            drive(1'b0, 0, 1'b1, 1'b0);
            mv++;
            chk_state("R6", 1'b0, 1'b0);
        end
        drive(1'b0, 0, 1'b1, 1'b0);
        chk_state("R7", 1'b1, 1'b0);
        drive(1'b0, 0, 1'b0, 1'b0);
        chk_state("R7", 1'b0, 1'b0);
    endtask

    task automatic t_down_sweep();
        for (int k = 0; k < MAX; k++) begin
            drive(1'b0, 0, 1'b0, 1'b1);
            mv--;
            chk_state("R6", 1'b0, 1'b0);
        end
        drive(1'b0, 0, 1'b0, 1'b1);
        chk_state("R7", 1'b0, 1'b1);
        drive(1'b0, 0, 1'b0, 1'b0);
        chk_state("R7", 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        drive(1'b1, 0, 1'b0, 1'b1);
        mv = 0;
        chk_state("R8", 1'b0, 1'b0);
        drive(1'b1, 26, 1'b1, 1'b0);
        mv = 26;
        chk_state("R8", 1'b0, 1'b0);
        drive(1'b1, 26, 1'b1, 1'b0);
        chk_state("R8", 1'b0, 1'b0);
        drive(1'b1, 7, 1'b1, 1'b1);
        mv = 7;
        chk_state("R8", 1'b0, 1'b0);
    endtask

    task automatic t_cancel();
        drive(1'b0, 0, 1'b1, 1'b1);
        chk_state("R9", 1'b0, 1'b0);
        drive(1'b1, 0, 1'b0, 1'b0);
        mv = 0;
        drive(1'b0, 0, 1'b1, 1'b1);
        chk_state("R9", 1'b0, 1'b0);
        drive(1'b1, 26, 1'b0, 1'b0);
        mv = 26;
        drive(1'b0, 0, 1'b1, 1'b1);
        chk_state("R9", 1'b0, 1'b0);
    endtask

    task automatic t_latency();
        drive(1'b1, 10, 1'b0, 1'b0);
        mv = 10;
        @(negedge clk);
        up_step = 1'b1;
        #5;
        chk(int'(cur_val) == 10, "R10", "cur_val before edge", int'(cur_val), 10);
        chk(trim_word == word_of(10), "R10", "word before edge",
            int'(trim_word), int'(word_of(10)));
        @(negedge clk);
        up_step = 1'b0;
        mv = 11;
        chk_state("R10", 1'b0, 1'b0);
        drive(1'b0, 0, 1'b0, 1'b0);
        chk_state("R10", 1'b0, 1'b0);
    endtask

    task automatic t_reset_mid();
        drive(1'b1, 19, 1'b0, 1'b0);
        mv = 19;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mv = 0;
        chk_state("R1", 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_loads();
        t_up_sweep();
        t_down_sweep();
        t_priority();
        t_cancel();
        t_latency();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule